// File: doc/BRIEF.md
# One-Wire Bit-Slot Master Engine

This block times the individual slots of a one-wire bus master on an open-drain line. A client asks for one of three operations through a valid/ready handshake: a bus reset, a byte write or a byte read. The engine pulls the line low for a fixed time in every slot. It watches for the line to rise again through a synchronizer and an edge detector, and it records the microsecond at which the last rising edge of the slot arrived.

A prescaler divides the system clock into a 1 µs time base. Every duration is a whole number of these ticks. When a bit slot ends, the recorded rise time is compared with a one/zero threshold, which decodes the bit. When a reset ends, the rise time is compared with a presence threshold, which tells whether a device answered. Bytes are sent and received least significant bit first. Bit slots follow one another with no gap. Between operations the line is always released.

Sequencing of device commands belongs to the client. The engine only turns a single request into the slots on the wire and reports the result with a one-cycle completion pulse.

Top module: `owm_slot_engine`

## Requirements
- R1: While reset is applied and in the first cycle after it, `req_ready` is 1 and `line_drive_low`, `done`, `presence` and `rx_byte` are all 0.
- R2: A request is taken in a cycle where `req_valid` and `req_ready` are both 1. `req_op` = 2'b00 selects a reset, 2'b01 a write and 2'b1x a read. `req_ready` is 0 from the cycle after acceptance until the operation ends. `done` is then 1 for exactly one cycle, and `req_ready` returns to 1 in that same cycle. A request raised while busy is never taken.
- R3: The slot time unit is CLK_DIV clock cycles (1 µs), counted from the clock edge that asserts `line_drive_low` for the slot. Every low time and every slot period is an exact multiple of this unit.
- R4: A write slot for a 1 bit drives low for 6 µs, and one for a 0 bit drives low for 60 µs. Every bit slot lasts 70 µs, and the next slot of the same byte starts in the cycle the previous one ends.
- R5: A write sends `req_data` bit 0 first and bit 7 last.
- R6: A read slot drives low for 6 µs. The received bit is 1 if the last rise of the synchronized line in that slot came before microsecond 15 of the slot, and 0 if it came at microsecond 15 or later. The first received bit goes to `rx_byte` bit 0.
- R7: A reset is a single 1000 µs slot that begins with a 480 µs low pulse.
- R8: After a reset, `presence` is 1 when the last rise in the slot came at or after microsecond 495 (reset low time plus 15 µs), and 0 when it came earlier.
- R9: Whenever `req_ready` is 1, `line_drive_low` is 0.
- R10: `rx_byte` changes only when a read completes, and `presence` changes only when a reset completes. Writes leave both unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | Operation: 00 reset, 01 write, 1x read |
| req_data | input | DATA_W | Byte to write |
| req_ready | output | 1 | Engine idle, request can be taken |
| done | output | 1 | One-cycle pulse when an operation ends |
| rx_byte | output | DATA_W | Last byte read from the bus |
| presence | output | 1 | Result of the last reset: a device answered |
| line_drive_low | output | 1 | Open-drain enable: 1 pulls the line low |
| line_in | input | 1 | Raw, asynchronous level of the bus line |

## Verification
The bench models the bus as a wired AND of the engine's drive and a simulated device. It releases the line one microsecond either side of each threshold: rises at 14 and 15 µs in read slots, and at 494 and 495 µs after a reset. An off-by-one in the threshold compare, or a synchronizer latency that spills into the next microsecond, therefore flips a decoded bit or the presence flag. It measures every low pulse and every slot period in clock cycles. A wrong prescaler, a write bit picked in MSB-first order, or a one-cycle gap between chained slots shows up as a length mismatch. It also raises a request in the middle of a write and checks that nothing starts afterwards, and it checks that writes leave the read byte and presence flag untouched.

// File: rtl/owm_pkg.sv
`timescale 1ns/1ps
package owm_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_RESET = 2'd1,
      ST_BITS  = 2'd2
   } owm_state_e;

   localparam logic [1:0] OP_RESET = 2'b00;
   localparam logic [1:0] OP_WRITE = 2'b01;

endpackage

// File: rtl/owm_tick_gen.sv
`timescale 1ns/1ps
// Divides the system clock into the 1 us slot time base.
// Restarting the count on slot start keeps every slot edge-aligned.
module owm_tick_gen #(
   parameter int DIV = 72
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   output logic tick
);
   localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(DIV - 1);

   generate
      if (DIV < 2) begin : g_bad_div
         $error("owm_tick_gen: DIV must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clear || cnt == LAST) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   assign tick = (cnt == LAST);

endmodule

// File: rtl/owm_line_sync.sv
`timescale 1ns/1ps
// Multi-flop synchronizer for the bus line plus a rising-edge detector.
module owm_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_in,
   output logic rise
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("owm_line_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;
   logic              prev;

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) chain[gi] <= 1'b1;
               else        chain[gi] <= line_in;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) chain[gi] <= 1'b1;
               else        chain[gi] <= chain[gi-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) prev <= 1'b1;
      else        prev <= chain[STAGES-1];
   end

   assign rise = chain[STAGES-1] & ~prev;

endmodule

// File: rtl/owm_slot_timer.sv
`timescale 1ns/1ps
// Times one slot: low phase, release phase, and the capture of the
// microsecond of the last rising edge. A start in the ending cycle
// chains the next slot with no gap.
module owm_slot_timer #(
   parameter int US_W = 10
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [US_W-1:0] low_len,
   input  logic [US_W-1:0] period_len,
   input  logic            tick,
   input  logic            rise,
   output logic            drive_low,
   output logic            slot_end,
   output logic [US_W-1:0] cap
);
   logic            active;
   logic [US_W-1:0] us_cnt;
   logic [US_W-1:0] low_q;
   logic [US_W-1:0] period_q;
   logic            at_last_us;

   assign at_last_us = (us_cnt == period_q - 1'b1);
   assign slot_end   = active & tick & at_last_us;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active    <= 1'b0;
         us_cnt    <= '0;
         low_q     <= '0;
         period_q  <= '0;
         drive_low <= 1'b0;
         cap       <= '0;
      end else if (start) begin
         active    <= 1'b1;
         us_cnt    <= '0;
         low_q     <= low_len;
         period_q  <= period_len;
         drive_low <= 1'b1;
         cap       <= period_len;   // no rise seen reads as "late"
      end else if (active) begin
         if (rise) begin
            cap <= us_cnt;
         end
         if (tick) begin
            if (at_last_us) begin
               active <= 1'b0;
            end else begin
               us_cnt <= us_cnt + 1'b1;
            end
            if (us_cnt + 1'b1 == low_q) begin
               drive_low <= 1'b0;
            end
         end
      end
   end

endmodule

// File: rtl/owm_slot_engine.sv
`timescale 1ns/1ps
module owm_slot_engine #(
   parameter int CLK_DIV        = 72,
   parameter int DATA_W         = 8,
   parameter int BIT_US         = 70,
   parameter int W1_LOW_US      = 6,
   parameter int W0_LOW_US      = 60,
   parameter int ONE_THRESH_US  = 15,
   parameter int RST_LOW_US     = 480,
   parameter int RST_SLOT_US    = 1000,
   parameter int PRES_MARGIN_US = 15,
   parameter int SYNC_STAGES    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_op,
   input  logic [DATA_W-1:0] req_data,
   output logic              req_ready,
   output logic              done,
   output logic [DATA_W-1:0] rx_byte,
   output logic              presence,
   output logic              line_drive_low,
   input  logic              line_in
);
   import owm_pkg::*;

   localparam int US_W  = $clog2(RST_SLOT_US + 1);
   localparam int IDX_W = $clog2(DATA_W);
   localparam logic [US_W-1:0]  BIT_P   = US_W'(BIT_US);
   localparam logic [US_W-1:0]  W1_L    = US_W'(W1_LOW_US);
   localparam logic [US_W-1:0]  W0_L    = US_W'(W0_LOW_US);
   localparam logic [US_W-1:0]  ONE_TH  = US_W'(ONE_THRESH_US);
   localparam logic [US_W-1:0]  RST_L   = US_W'(RST_LOW_US);
   localparam logic [US_W-1:0]  RST_P   = US_W'(RST_SLOT_US);
   localparam logic [US_W-1:0]  PRES_TH = US_W'(RST_LOW_US + PRES_MARGIN_US);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

   generate
      if (DATA_W < 4) begin : g_bad_width
         $error("owm_slot_engine: DATA_W must be at least 4");
      end
      if (W1_LOW_US < 1 || W1_LOW_US >= W0_LOW_US || W0_LOW_US >= BIT_US) begin : g_bad_bit
         $error("owm_slot_engine: need 0 < W1_LOW_US < W0_LOW_US < BIT_US");
      end
      if (ONE_THRESH_US <= W1_LOW_US || ONE_THRESH_US >= BIT_US) begin : g_bad_thresh
         $error("owm_slot_engine: ONE_THRESH_US must lie inside the release phase");
      end
      if (RST_LOW_US + PRES_MARGIN_US >= RST_SLOT_US || BIT_US > RST_SLOT_US) begin : g_bad_reset
         $error("owm_slot_engine: reset timing does not fit its slot");
      end
   endgenerate

   owm_state_e        state;
   logic              rd_q;
   logic [DATA_W-2:0] tx_q;
   logic [DATA_W-2:0] rx_sh;
   logic [IDX_W-1:0]  bit_idx;

   logic              accept;
   logic              tick;
   logic              rise;
   logic              slot_end;
   logic [US_W-1:0]   cap;
   logic              tmr_start;
   logic              next_one;
   logic [US_W-1:0]   low_sel;
   logic [US_W-1:0]   period_sel;
   logic              rx_bit;
   logic              more_bits;

   assign req_ready = (state == ST_IDLE);
   assign accept    = req_valid & req_ready;
   assign more_bits = (state == ST_BITS) && (bit_idx != LAST_IDX);
   assign tmr_start = accept | (slot_end & more_bits);
   assign rx_bit    = (cap < ONE_TH);

   // Parameters of the slot being started this cycle.
   always_comb begin
      if (accept) begin
         next_one = req_op[1] | req_data[0];
      end else begin
         next_one = rd_q | tx_q[0];
      end
      if (accept && req_op == OP_RESET) begin
         low_sel    = RST_L;
         period_sel = RST_P;
      end else begin
         low_sel    = next_one ? W1_L : W0_L;
         period_sel = BIT_P;
      end
   end

   owm_tick_gen #(.DIV(CLK_DIV)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (tmr_start),
      .tick  (tick)
   );

   owm_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .line_in (line_in),
      .rise    (rise)
   );

   owm_slot_timer #(.US_W(US_W)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (tmr_start),
      .low_len    (low_sel),
      .period_len (period_sel),
      .tick       (tick),
      .rise       (rise),
      .drive_low  (line_drive_low),
      .slot_end   (slot_end),
      .cap        (cap)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         rd_q     <= 1'b0;
         tx_q     <= '0;
         rx_sh    <= '0;
         bit_idx  <= '0;
         done     <= 1'b0;
         rx_byte  <= '0;
         presence <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (accept) begin
                  state   <= (req_op == OP_RESET) ? ST_RESET : ST_BITS;
                  rd_q    <= req_op[1];
                  tx_q    <= req_data[DATA_W-1:1];
                  bit_idx <= '0;
               end
            end
            ST_RESET: begin
               if (slot_end) begin
                  presence <= (cap >= PRES_TH);
                  done     <= 1'b1;
                  state    <= ST_IDLE;
               end
            end
            ST_BITS: begin
               if (slot_end) begin
                  tx_q    <= {1'b0, tx_q[DATA_W-2:1]};
                  rx_sh   <= {rx_bit, rx_sh[DATA_W-2:1]};
                  bit_idx <= bit_idx + 1'b1;
                  if (bit_idx == LAST_IDX) begin
                     done  <= 1'b1;
                     state <= ST_IDLE;
                     if (rd_q) begin
                        rx_byte <= {rx_bit, rx_sh};
                     end
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/owm_slot_checker.sv
`timescale 1ns/1ps
module owm_slot_checker #(
   parameter int CLK_DIV    = 72,
   parameter int DATA_W     = 8,
   parameter int W1_LOW_US  = 6,
   parameter int W0_LOW_US  = 60,
   parameter int RST_LOW_US = 480
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              done,
   input logic              line_drive_low,
   input logic              presence,
   input logic [DATA_W-1:0] rx_byte
);
   localparam int RUN_W = $clog2(RST_LOW_US * CLK_DIV + 2) + 1;
   localparam logic [RUN_W-1:0] RUN_W1  = RUN_W'(W1_LOW_US * CLK_DIV);
   localparam logic [RUN_W-1:0] RUN_W0  = RUN_W'(W0_LOW_US * CLK_DIV);
   localparam logic [RUN_W-1:0] RUN_RST = RUN_W'(RST_LOW_US * CLK_DIV);

   // Length of the current run of cycles with the line pulled low.
   logic [RUN_W-1:0] run_cnt;
   always_ff @(posedge clk) begin
      if (!rst_n)              run_cnt <= '0;
      else if (line_drive_low) run_cnt <= run_cnt + 1'b1;
      else                     run_cnt <= '0;
   end

   assert_idle_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !line_drive_low);

   assert_accept_goes_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_with_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> req_ready);

   assert_presence_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(presence) |-> done);

   assert_rx_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rx_byte) |-> done);

   // R3, R4, R7: every low pulse has one of the three legal lengths.
   assert_low_length_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(line_drive_low) |-> (run_cnt == RUN_W1 || run_cnt == RUN_W0 || run_cnt == RUN_RST));

   assert_low_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
      line_drive_low |-> (run_cnt < RUN_RST));

endmodule

bind owm_slot_engine owm_slot_checker #(
   .CLK_DIV    (CLK_DIV),
   .DATA_W     (DATA_W),
   .W1_LOW_US  (W1_LOW_US),
   .W0_LOW_US  (W0_LOW_US),
   .RST_LOW_US (RST_LOW_US)
) u_owm_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .req_valid      (req_valid),
   .req_ready      (req_ready),
   .done           (done),
   .line_drive_low (line_drive_low),
   .presence       (presence),
   .rx_byte        (rx_byte)
);

// File: tb/tb_owm_slot_engine.sv
`timescale 1ns/1ps
module tb_owm_slot_engine;
   localparam int DIV      = 8;
   localparam int BIT_CYC  = 70 * DIV;
   localparam int W1_CYC   = 6 * DIV;
   localparam int W0_CYC   = 60 * DIV;
   localparam int RSTL_CYC = 480 * DIV;
   localparam int RSTP_CYC = 1000 * DIV;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic [1:0] req_op = 2'b00;
   logic [7:0] req_data = 8'h00;
   logic       dev_pull = 1'b0;
   wire        req_ready, done, presence, line_drive_low, line_in;
   wire  [7:0] rx_byte;

   assign line_in = !(line_drive_low | dev_pull);

   always #2 clk = ~clk;

   owm_slot_engine #(.CLK_DIV(DIV)) dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .req_valid      (req_valid),
      .req_op         (req_op),
      .req_data       (req_data),
      .req_ready      (req_ready),
      .done           (done),
      .rx_byte        (rx_byte),
      .presence       (presence),
      .line_drive_low (line_drive_low),
      .line_in        (line_in)
   );

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   // Expected decoded read byte: bits whose device release lands at or
   // after the threshold read as 0.
   function automatic logic [7:0] exp_read(input logic [7:0] bits);
      return bits;
   endfunction

   // op: 00 reset, 01 write, 1x read.
   // reset: rel0 = microsecond the device releases (0: device silent).
   // read: zero bits are held low until rel0, one bits until rel1 (0: not held).
   task automatic xfer(input logic [1:0] op, input logic [7:0] wdata,
                       input logic [7:0] rbits, input int rel0, input int rel1,
                       input bit poke, output logic [7:0] got);
      int nslots;
      nslots = (op == 2'b00) ? 1 : 8;
      @(negedge clk);
      req_valid = 1'b1; req_op = op; req_data = wdata;
      @(negedge clk);
      req_valid = 1'b0;
      chk(req_ready == 1'b0, "R2", "busy after accept", req_ready, 0);
      for (int s = 0; s < nslots; s++) begin
         bit one;
         int lo_exp, per, lo_meas, p_on, p_off, rel;
         one     = op[1] ? rbits[s] : wdata[s];
         lo_exp  = (op == 2'b00) ? RSTL_CYC : ((op[1] || one) ? W1_CYC : W0_CYC);
         per     = (op == 2'b00) ? RSTP_CYC : BIT_CYC;
         lo_meas = -1;
         p_on    = -1;
         p_off   = -1;
         if (op == 2'b00) begin
            if (rel0 > 0) begin p_on = 485 * DIV; p_off = rel0 * DIV; end
         end else if (op[1]) begin
            rel = one ? rel1 : rel0;
            if (rel > 0) begin p_on = 0; p_off = rel * DIV; end
         end
         chk(line_drive_low == 1'b1, "R4", "slot start drives low", line_drive_low, 1);
         if (p_on == 0) dev_pull = 1'b1;
         for (int n = 1; n <= per; n++) begin
            @(negedge clk);
            if (lo_meas < 0 && !line_drive_low) lo_meas = n;
            if (n == p_on)  dev_pull = 1'b1;
            if (n == p_off) dev_pull = 1'b0;
            if (poke && s == 2 && n == 10) begin req_valid = 1'b1; req_op = 2'b10; end
            if (poke && s == 2 && n == 30) req_valid = 1'b0;
         end
         dev_pull = 1'b0;
         if (op == 2'b00) chk(lo_meas == lo_exp, "R7", "reset low cycles", lo_meas, lo_exp);
         else if (op[1])  chk(lo_meas == lo_exp, "R6", "read low cycles", lo_meas, lo_exp);
         else             chk(lo_meas == lo_exp, "R5", "write low cycles (R3 R4)", lo_meas, lo_exp);
         if (s < nslots - 1)
            chk(line_drive_low == 1'b1 && done == 1'b0, "R4", "next slot at period end",
                line_drive_low, 1);
         else
            chk(done == 1'b1 && req_ready == 1'b1, "R2", "done and ready at period end",
                {done, req_ready}, 3);
      end
      got = rx_byte;
      begin
         int stray;
         stray = 0;
         @(negedge clk);
         chk(done == 1'b0, "R2", "done lasts one cycle", done, 0);
         for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (line_drive_low || !req_ready) stray++;
         end
         chk(stray == 0, "R9", "line released and idle after op", stray, 0);
      end
   endtask

   initial begin
      repeat (195000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL R2 watchdog expired: actual %0d expected %0d", 1, 0);
         summary();
         $finish;
      end
   end

   initial begin
      logic [7:0] got, prev_rx;
      logic       prev_pres;
      int unsigned seed_init;
      seed_init = $urandom(32'd2024);

      repeat (5) @(negedge clk);
      chk(req_ready == 1'b1 && line_drive_low == 1'b0 && done == 1'b0,
          "R1", "handshake and line in reset", {req_ready, line_drive_low, done}, 4);
      chk(presence == 1'b0 && rx_byte == 8'h00, "R1", "result outputs in reset",
          {presence, rx_byte}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1 && line_drive_low == 1'b0, "R1", "idle after reset",
          {req_ready, line_drive_low}, 2);

      // R8: device answers, rise at 610 us.
      xfer(2'b00, 8'h00, 8'h00, 610, 0, 1'b0, got);
      chk(presence == 1'b1, "R8", "device present", presence, 1);

      // R5, R10: write leaves results alone.
      xfer(2'b01, 8'h5A, 8'h00, 0, 0, 1'b0, got);
      chk(rx_byte == 8'h00 && presence == 1'b1, "R10", "write keeps results",
          {presence, rx_byte}, 9'h100);

      // R6: mixed read.
      xfer(2'b10, 8'h00, 8'h96, 30, 0, 1'b0, got);
      chk(got == exp_read(8'h96), "R6", "read mixed byte", got, 8'h96);

      // R6 corner: ones held until 14 us still read 1.
      xfer(2'b10, 8'h00, 8'hFF, 30, 14, 1'b0, got);
      chk(got == 8'hFF, "R6", "rise at 14 us decodes 1", got, 8'hFF);

      // R6 corner: zeros released at exactly 15 us read 0.
      xfer(2'b11, 8'h00, 8'h00, 15, 0, 1'b0, got);
      chk(got == 8'h00, "R6", "rise at 15 us decodes 0", got, 8'h00);

      // R2: request during a write is not taken; R10 results kept.
      xfer(2'b01, 8'hC3, 8'h00, 0, 0, 1'b1, got);
      chk(rx_byte == 8'h00, "R10", "rx kept after poked write", rx_byte, 0);

      // R8 corners.
      xfer(2'b00, 8'h00, 8'h00, 0, 0, 1'b0, got);
      chk(presence == 1'b0, "R8", "no device", presence, 0);
      xfer(2'b00, 8'h00, 8'h00, 494, 0, 1'b0, got);
      chk(presence == 1'b0, "R8", "rise at 494 us absent", presence, 0);
      xfer(2'b00, 8'h00, 8'h00, 495, 0, 1'b0, got);
      chk(presence == 1'b1, "R8", "rise at 495 us present", presence, 1);

      // Random mix of reads and writes.
      for (int i = 0; i < 12; i++) begin
         logic [1:0] op;
         logic [7:0] d;
         int r0, r1;
         op = ($urandom_range(0, 1) == 0) ? 2'b01 : ($urandom_range(0, 1) ? 2'b10 : 2'b11);
         d  = 8'($urandom_range(0, 255));
         r0 = $urandom_range(16, 50);
         r1 = ($urandom_range(0, 1) == 0) ? 0 : $urandom_range(8, 14);
         prev_rx   = rx_byte;
         prev_pres = presence;
         xfer(op, d, d, r0, r1, 1'b0, got);
         if (op[1]) begin
            chk(got == exp_read(d), "R6", "random read", got, d);
         end else begin
            chk(rx_byte == prev_rx, "R10", "random write keeps rx", rx_byte, prev_rx);
         end
         chk(presence == prev_pres, "R10", "presence kept", presence, prev_pres);
      end

      finished = 1'b1;
      summary();
      $finish;
   end

endmodule